// File: doc/BRIEF.md
# Serial Shift-Clock Rate Generator

This block makes the shift clock for a synchronous serial port. A down-counter, clocked by the module clock, is loaded from a programmed reload value. Every time the counter runs out it reloads and flips the shift-clock level. Each half period therefore lasts reload+1 module-clock cycles, and the shift clock runs at the module clock divided by 2×(reload+1). On every flip of the level, a one-cycle tick marks the edge for the shift logic downstream.

The reload value is held in a single register with a write port and a read port. The read port's meaning depends on the channel enable:
- While the channel is disabled, a read returns the programmed reload value, and writes are accepted.
- While the channel is enabled, a read returns the live counter, and writes are dropped.

A mode input selects master or slave. A zero reload, which gives clock/2, is honoured only in master mode. In slave mode a zero reload is run as 1, which gives clock/4.

Top module: `sclk_rate_gen`

## Requirements
- R1: After reset the shift-clock level is 0, the tick is 0, and the read port returns reload value 0.
- R2: While enabled with effective reload E, the level after the n-th clock edge since enable (n=0 being the edge that sees enable first) equals floor(n/(E+1)) mod 2. This gives a full shift-clock period of 2×(E+1) cycles.
- R3: While enabled, the read port returns the live count, which is E − (n mod (E+1)) after edge n.
- R4: While disabled, the read port returns the programmed reload value exactly as written. This includes 0 in slave mode.
- R5: A write presented while the channel is enabled has no effect: the reload value and the running count are unchanged.
- R6: The first enabled edge loads the counter and holds the level low. One cycle after the channel is disabled, level and tick are both 0.
- R7: Effective reload E equals the programmed value, except that a programmed 0 in slave mode (mode input 0) is run as E=1. In master mode (mode input 1) a reload of 0 toggles the level on every edge.
- R8: The tick is 1 for exactly the cycles after edges n ≥ 1 where n mod (E+1) = 0. These are the cycles in which the level has just changed, rising or falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | 1 | Serial channel enable |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| wr_en | input | 1 | Reload write strobe (accepted only while disabled) |
| wr_data | input | CNT_W | Reload value to write |
| rd_data | output | CNT_W | Live count when enabled, reload value when disabled |
| sclk_level | output | 1 | Shift-clock level, idle 0 |
| sclk_tick | output | 1 | One-cycle pulse on every shift-clock edge |

## Verification
A wrong count or reload state shows up on the read port in the very next cycle, because the read port exposes the counter while the channel is enabled. It also shows up as a level flip that comes early or late within one half period, at most reload+1 cycles. A corrupted reload register shows up on the read port as soon as the channel is disabled. A write that was not blocked while enabled therefore shows up one cycle after disable, or as a shifted half period on the next wrap. The benches sweep small reload values in both modes, compare every cycle against arithmetic expectations, and cover the zero-reload corner in each mode.

// File: rtl/sclk_pkg.sv
// Shared definitions for the shift-clock rate generator.
// Assumes: nothing beyond standard SystemVerilog.
package sclk_pkg;
    // Default counter width
    parameter int unsigned RG_CNT_W_DEF = 16;

    // Serial port role as seen on the mode input
    typedef enum logic {
        RG_SLAVE  = 1'b0,
        RG_MASTER = 1'b1
    } rg_mode_e;
endpackage

// File: rtl/rg_reload_reg.sv
// Holds the programmed reload value and derives the effective reload.
// Assumes: writes are legal only while the channel is disabled; writes
// seen while enabled are dropped. Slave mode forbids a reload of 0.
module rg_reload_reg
    import sclk_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chan_en,
    input  logic         is_master,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] reload_q,
    output logic [W-1:0] eff_reload
);
    localparam logic [W-1:0] SLAVE_MIN = W'(1);

    rg_mode_e mode;
    assign mode = rg_mode_e'(is_master);

    // Capture the reload value when a write arrives while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_en && !chan_en) begin
            reload_q <= wr_data;
        end
    end

    // Raise a zero reload to the slave minimum in slave mode
    always_comb begin
        eff_reload = reload_q;
        if (mode == RG_SLAVE && reload_q == '0) begin
            eff_reload = SLAVE_MIN;
        end
    end
endmodule

// File: rtl/rg_down_cnt.sv
// Down-counter that reloads at zero and flags the wrap.
// Assumes: run is low for at least the enable edge, so the counter is
// loaded from eff_reload before it starts counting.
module rg_down_cnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] eff_reload,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    // The wrap is raised when a running count has reached zero
    assign wrap = run && (cnt_q == '0);

    // Load when idle or at the wrap, otherwise count down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= eff_reload;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/rg_sclk_tog.sv
// Shift-clock level toggle and the edge tick.
// Assumes: wrap comes straight from the counter and is only high while
// running; the level idles low when not running.
module rg_sclk_tog (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wrap,
    output logic level_q,
    output logic tick_q
);
    // Flip the level on each wrap; park it low when not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            level_q <= 1'b0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= wrap;
            if (wrap) begin
                level_q <= ~level_q;
            end
        end
    end
endmodule

// File: rtl/sclk_rate_gen.sv
// Top of the shift-clock rate generator. It ties together the reload
// register, the down-counter and the level toggle, and drives the
// read-port multiplexer.
// Assumes: chan_en and is_master are synchronous to clk; wr_en is
// only meaningful while chan_en is low.
module sclk_rate_gen
    import sclk_pkg::*;
#(
    parameter int unsigned CNT_W = RG_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             is_master,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             sclk_level,
    output logic             sclk_tick
);
    logic             en_q;
    logic             run;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] eff_reload;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    // Remember last cycle's enable so the first enabled edge only loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= chan_en;
        end
    end

    assign run = chan_en && en_q;

    rg_reload_reg #(.W(CNT_W)) u_reload (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .is_master  (is_master),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .reload_q   (reload_q),
        .eff_reload (eff_reload)
    );

    rg_down_cnt #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .eff_reload (eff_reload),
        .cnt_q      (cnt_q),
        .wrap       (wrap)
    );

    rg_sclk_tog u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .wrap    (wrap),
        .level_q (sclk_level),
        .tick_q  (sclk_tick)
    );

    // Read port: live count while enabled, programmed value otherwise
    assign rd_data = chan_en ? cnt_q : reload_q;
endmodule

// File: rtl/sclk_rate_gen_chk.sv
// Temporal checks on the shift-clock rate generator, bound to the top.
// Assumes: reset is held for at least one edge with chan_en low.
module sclk_rate_gen_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         chan_en,
    input logic         is_master,
    input logic         en_q,
    input logic [W-1:0] cnt,
    input logic [W-1:0] reload,
    input logic         level,
    input logic         tick
);
    localparam logic [W-1:0] ONE = W'(1);

    // R5: the reload value cannot change across an enabled cycle
    a_r5_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(reload));

    // R3: a running non-zero count steps down by one
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && en_q && cnt != '0) |=> (!chan_en || cnt == $past(cnt) - ONE));

    // R8: a tick always comes with a level change
    a_r8_tick_flips: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (level != $past(level)));

    // R6: after a disabled cycle the outputs are idle
    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(chan_en) |-> (!level && !tick));

    // R7: in slave mode two ticks never come back to back
    a_r7_slave_min: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !$past(is_master)) |=> !tick);
endmodule

bind sclk_rate_gen sclk_rate_gen_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .is_master (is_master),
    .en_q      (en_q),
    .cnt       (cnt_q),
    .reload    (reload_q),
    .level     (sclk_level),
    .tick      (sclk_tick)
);

// File: tb/sclk_rate_gen_tb.sv
module sclk_rate_gen_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         chan_en = 1'b0;
    logic         is_master = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         sclk_level;
    logic         sclk_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sclk_rate_gen #(.CNT_W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .is_master  (is_master),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .sclk_level (sclk_level),
        .sclk_tick  (sclk_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic program_reload(input int val);
        @(negedge clk);
        chan_en = 1'b0;
        wr_en   = 1'b1;
        wr_data = W'(val);
        @(negedge clk);
        wr_en   = 1'b0;
        check("R4 readback", int'(rd_data), val);
    endtask

    // Enables the channel, checks ncyc edges, then disables the channel.
    // If poke >= 0, a write of poke is attempted while running (R5).
    task automatic run_case(input bit master, input int r, input int ncyc, input int poke);
        int e;
        e = (!master && r == 0) ? 1 : r;
        program_reload(r);
        is_master = master;
        chan_en   = 1'b1;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            if (n == 2 && poke >= 0) begin
                wr_en   = 1'b1;
                wr_data = W'(poke);
            end else begin
                wr_en = 1'b0;
            end
            check("R2 level", int'(sclk_level), (n / (e + 1)) % 2);
            check("R8 tick", int'(sclk_tick), (n >= 1 && n % (e + 1) == 0) ? 1 : 0);
            check(master ? "R3 count" : "R7 slave count", int'(rd_data), e - (n % (e + 1)));
        end
        wr_en   = 1'b0;
        chan_en = 1'b0;
        @(negedge clk);
        check("R6 idle level", int'(sclk_level), 0);
        check("R6 idle tick", int'(sclk_tick), 0);
        check(poke >= 0 ? "R5 write ignored" : "R4 reload kept", int'(rd_data), r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 level", int'(sclk_level), 0);
        check("R1 tick", int'(sclk_tick), 0);
        check("R1 reload", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < 8; r++) run_case(1'b1, r, 3 * (r + 1) + 2, -1);
        for (int r = 0; r < 8; r++) run_case(1'b0, r, 3 * (r + 1) + 2, -1);
        run_case(1'b1, 19, 45, -1);
        run_case(1'b0, 3, 12, 9);
        run_case(1'b1, 0, 6, 5);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule